// File: doc/BRIEF.md
# SD Command Frame Transmitter

This block sends one 48-bit SD-bus command frame on the CMD line, one bit per card-clock period. Software supplies a 6-bit command index and a 32-bit argument, then pulses a go input. The block builds the rest of the frame itself: the leading zero start bit, the host-direction bit, the CRC-7 and the closing one bit.

The block also makes the card clock from the engine clock through a programmable divider. The card clock runs only while a frame is in flight and sits low at all other times. A busy flag acts as the command-output enable bit. It is set when a frame is accepted and drops by itself after the last bit. The CMD output-enable is high only while the block is sending, so the line can be shared with a response path outside this block.

CMD changes while the card clock falls, so a card can sample it on the rising edge. With a divider value of zero, the card clock runs at the full engine rate. The block still places one bit in each card-clock period.

Top module: `sd_cmd_tx`

## Requirements
- R1: After reset, cmd_busy_o is 0, sd_cmd_oe_o is 0, sd_cmd_o is 1 and sd_clk_o is 0.
- R2: The 48 bits seen on sd_cmd_o at the 48 rising edges of sd_clk_o are, first to last: 0, then 1, then the index bits 5 down to 0, then the argument bits 31 down to 0, then the CRC bits 6 down to 0, then 1.
- R3: The CRC field is the CRC-7 of the first 40 frame bits, with generator x^7 + x^3 + 1 and a zero initial value. For example, index 0 with argument 0 gives 7'h4A, and index 8 with argument 32'h1AA gives 7'h43.
- R4: A cycle with cmd_go_i high while idle sets cmd_busy_o on the next engine edge. cmd_busy_o clears by itself after exactly 48*(D+1) engine cycles, where D is the divider value.
- R5: Each frame has exactly 48 rising edges of sd_clk_o, one per bit. Each card-clock period is D+1 engine cycles, and D = 0 gives a card clock at the engine rate.
- R6: sd_clk_o stays low whenever no frame is in progress.
- R7: sd_cmd_oe_o is high exactly while a frame is sent. When the line is released, sd_cmd_o reads 1.
- R8: For D >= 1, sd_cmd_o changes only at an engine edge where sd_clk_o is driven low.
- R9: cmd_go_i pulses during a frame are ignored. Index, argument and divider are captured when a frame is accepted, so later changes to them do not alter the frame or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Engine clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| clk_div_i | input | DIV_W | Card-clock divider value D |
| cmd_go_i | input | 1 | Request to send a frame |
| cmd_busy_o | output | 1 | Command-output enable bit, self-clearing |
| sd_clk_o | output | 1 | Gated card clock |
| sd_cmd_o | output | 1 | CMD line data |
| sd_cmd_oe_o | output | 1 | CMD line output enable |

## Verification
The frame path is driven with four command/argument pairs that have published CRC values. This separates a wrong generator, a wrong initial value or a bit-order mistake from a correct CRC. All-ones and alternating-pattern frames catch a stuck or swapped shift position. Each frame runs at a different divider: 0 (the gated full-rate path), 1 and 2 (the even and odd high/low splits), larger values, and the maximum. Counting card-clock edges and busy cycles in each case confirms that one bit is sent per card-clock period. A go pulse with changed inputs in the middle of a frame shows that the captured values are held.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned ARG_W     = 32;
  localparam int unsigned CRC_W     = 7;
  localparam int unsigned BODY_W    = 2 + IDX_W + ARG_W;
  localparam int unsigned FRAME_W   = BODY_W + CRC_W + 1;
  localparam int unsigned BIT_CNT_W = $clog2(FRAME_W);
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
endpackage

// File: rtl/sd_crc7_calc.sv
module sd_crc7_calc
  import sd_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = BODY_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // Parallel form of the serial LFSR, unrolled over every input bit.
  always_comb begin
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = data_i[i] ^ acc[CRC_W-1];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    crc_o = acc;
  end
endmodule

// File: rtl/sd_cardclk_gen.sv
module sd_cardclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             sd_clk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             div_clk_q, div_clk_d;
  logic [DIV_W:0]   half_w;
  logic             fast_clk;

  // The high phase starts at ceil((D+1)/2) within each period.
  assign half_w = {1'b0, div_i >> 1} + (DIV_W+1)'(1);
  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == div_i) cnt_d = '0;
    else                    cnt_d = cnt_q + DIV_W'(1);
    div_clk_d = run_i && ({1'b0, cnt_d} >= half_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_clk_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      div_clk_q <= div_clk_d;
    end
  end

  // Full-rate path: run_i changes at the rising engine edge, while ~clk_i is
  // already low, so the gate cannot glitch.
  assign fast_clk = ~clk_i & run_i;
  assign sd_clk_o = (div_i == '0) ? fast_clk : div_clk_q;

  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !div_clk_q); // R6
  AST_TICK_ONCE_PER_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o); // R5
endmodule

// File: rtl/sd_frame_shifter.sv
module sd_frame_shifter
  import sd_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               tick_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               cmd_o,
  output logic               oe_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0]   sh_q, sh_d;
  logic [BIT_CNT_W-1:0] bit_q, bit_d;
  logic                 busy_q, busy_d;
  logic                 accept;

  assign accept = go_i && !busy_q;

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    if (accept) begin
      sh_d   = frame_i;
      bit_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q && tick_i) begin
      if (bit_q == LAST_BIT) begin
        busy_d = 1'b0;
        bit_d  = '0;
      end else begin
        sh_d  = {sh_q[FRAME_W-2:0], 1'b1};
        bit_d = bit_q + BIT_CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign oe_o   = busy_q;
  assign cmd_o  = busy_q ? sh_q[FRAME_W-1] : 1'b1;

  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !cmd_o); // R2
  AST_END_BIT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bit_q == LAST_BIT) |-> cmd_o); // R2
  AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(bit_q) == LAST_BIT && $past(tick_i))); // R4
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [5:0]       cmd_idx_i,
  input  logic [31:0]      cmd_arg_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic             cmd_go_i,
  output logic             cmd_busy_o,
  output logic             sd_clk_o,
  output logic             sd_cmd_o,
  output logic             sd_cmd_oe_o
);
  logic               rst_s1_q, rst_s2_q, rst_n;
  logic [BODY_W-1:0]  body;
  logic [CRC_W-1:0]   crc;
  logic [FRAME_W-1:0] frame;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               busy, tick, accept;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q;

  assign body  = {1'b0, 1'b1, cmd_idx_i, cmd_arg_i};
  assign frame = {body, crc, 1'b1};

  sd_crc7_calc #(.DATA_W(BODY_W)) i_crc (
    .data_i (body),
    .crc_o  (crc)
  );

  assign accept = cmd_go_i && !busy;

  always_comb begin
    div_d = div_q;
    if (accept) div_d = clk_div_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  sd_cardclk_gen #(.DIV_W(DIV_W)) i_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .run_i    (busy),
    .div_i    (div_q),
    .tick_o   (tick),
    .sd_clk_o (sd_clk_o)
  );

  sd_frame_shifter i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .go_i    (cmd_go_i),
    .tick_i  (tick),
    .frame_i (frame),
    .busy_o  (busy),
    .cmd_o   (sd_cmd_o),
    .oe_o    (sd_cmd_oe_o)
  );

  assign cmd_busy_o = busy;

  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && cmd_go_i) |=> $stable(div_q)); // R9
  AST_CMD_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_n)
    (div_q != '0 && !$stable(sd_cmd_o)) |-> !sd_clk_o); // R8
  AST_OE_RELEASED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(sd_cmd_oe_o) |-> sd_cmd_o); // R7
endmodule

// File: tb/test_sd_cmd_tx.sv
module test_sd_cmd_tx;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [5:0]  cmd_idx_i;
  logic [31:0] cmd_arg_i;
  logic [7:0]  clk_div_i;
  logic        cmd_go_i;
  logic        cmd_busy_o, sd_clk_o, sd_cmd_o, sd_cmd_oe_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sd_cmd_tx #(.DIV_W(8)) i_sd_cmd_tx (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmd_idx_i   (cmd_idx_i),
    .cmd_arg_i   (cmd_arg_i),
    .clk_div_i   (clk_div_i),
    .cmd_go_i    (cmd_go_i),
    .cmd_busy_o  (cmd_busy_o),
    .sd_clk_o    (sd_clk_o),
    .sd_cmd_o    (sd_cmd_o),
    .sd_cmd_oe_o (sd_cmd_oe_o)
  );

  // Layout: {known, crc[6:0], div[7:0], arg[31:0], idx[5:0]}
  localparam int NV = 6;
  localparam logic [53:0] VECS [NV] = '{
    {1'b1, 7'h4A, 8'd0,   32'h0000_0000, 6'd0},
    {1'b1, 7'h2A, 8'd1,   32'h0000_0000, 6'd17},
    {1'b1, 7'h43, 8'd2,   32'h0000_01AA, 6'd8},
    {1'b1, 7'h32, 8'd3,   32'h0000_0000, 6'd55},
    {1'b0, 7'h00, 8'd0,   32'hFFFF_FFFF, 6'd63},
    {1'b0, 7'h00, 8'd5,   32'hA5A5_5A5A, 6'd42}
  };

  // Card-side capture on the card clock.
  bit          cap_en = 1'b0;
  logic [47:0] cap;
  int          rises, oe_miss, stray;
  initial begin rises = 0; oe_miss = 0; stray = 0; cap = '0; end
  always @(posedge sd_clk_o) begin
    if (cap_en) begin
      cap = {cap[46:0], sd_cmd_o};
      rises++;
      if (!sd_cmd_oe_o) oe_miss++;
    end else begin
      stray++;
    end
  end

  function automatic logic [6:0] ref_crc(input logic [39:0] msg);
    logic [46:0] m;
    m = {msg, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
    return m[6:0];
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] b;
    b = {2'b01, idx, arg};
    return {b, ref_crc(b), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [5:0] idx, input logic [31:0] arg,
                           input logic [7:0] div, input bit poke,
                           input bit known, input logic [6:0] kcrc);
    int cyc;
    logic [47:0] expf;
    expf = ref_frame(idx, arg);
    @(negedge clk);
    cmd_idx_i = idx; cmd_arg_i = arg; clk_div_i = div;
    cap = '0; rises = 0; oe_miss = 0; cap_en = 1'b1;
    cmd_go_i = 1'b1;
    @(negedge clk);
    cmd_go_i = 1'b0;
    cyc = 0;
    while (cmd_busy_o && cyc < 20000) begin
      cyc++;
      if (poke && cyc == 10) begin
        cmd_go_i = 1'b1; cmd_idx_i = ~idx; cmd_arg_i = ~arg; clk_div_i = div + 8'd1;
      end else begin
        cmd_go_i = 1'b0;
      end
      @(negedge clk);
    end
    cap_en = 1'b0;
    chk(cyc == 48 * (int'(div) + 1), "R4 busy length", cyc, 48 * (int'(div) + 1));
    chk(rises == 48, "R5 card clock edges", rises, 48);
    chk(cap == expf, "R2 frame bits", cap, expf);
    chk(oe_miss == 0, "R7 oe during frame", oe_miss, 0);
    if (known) chk(cap[7:1] == kcrc, "R3 crc field", cap[7:1], kcrc);
    if (poke) chk(cap == expf && cyc == 48 * (int'(div) + 1), "R9 mid-frame go ignored", cap, expf);
    repeat (2) @(negedge clk);
    #1;
    chk(sd_clk_o == 1'b0, "R6 clock idle low", sd_clk_o, 0);
    chk(sd_cmd_oe_o == 1'b0 && sd_cmd_o == 1'b1, "R7 line released",
        {sd_cmd_oe_o, sd_cmd_o}, 2'b01);
  endtask

  initial begin
    rst_ni = 1'b0; cmd_go_i = 1'b0; cmd_idx_i = '0; cmd_arg_i = '0; clk_div_i = '0;
    repeat (3) @(negedge clk);
    chk(cmd_busy_o == 1'b0 && sd_cmd_oe_o == 1'b0 && sd_cmd_o == 1'b1 && sd_clk_o == 1'b0,
        "R1 reset state", {cmd_busy_o, sd_cmd_oe_o, sd_cmd_o, sd_clk_o}, 4'b0010);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_busy_o == 1'b0 && sd_cmd_oe_o == 1'b0 && sd_cmd_o == 1'b1 && sd_clk_o == 1'b0,
        "R1 after release", {cmd_busy_o, sd_cmd_oe_o, sd_cmd_o, sd_clk_o}, 4'b0010);

    for (int v = 0; v < NV; v++)
      run_frame(VECS[v][5:0], VECS[v][37:6], VECS[v][45:38], 1'b0, VECS[v][53], VECS[v][52:46]);

    // R9: go pulse with new inputs in the middle of a frame
    run_frame(6'd12, 32'h1234_5678, 8'd2, 1'b1, 1'b0, 7'h0);
    run_frame(6'd7, 32'h0F0F_F0F0, 8'd0, 1'b1, 1'b0, 7'h0);
    // Largest divider
    run_frame(6'd41, 32'hDEAD_BEEF, 8'd255, 1'b0, 1'b0, 7'h0);
    // Back-to-back frame right after one completes
    run_frame(6'd0, 32'h0000_0000, 8'd1, 1'b0, 1'b1, 7'h4A);

    chk(stray == 0, "R6 no card clock edge while idle", stray, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule